// File: doc/BRIEF.md
# Disk Controller Auto-Powerdown Controller

This block decides when the disk-controller logical device is powered down. Three requests can put it there. A direct powerdown configuration bit does so unconditionally. A powerdown bit in the data-rate register does so while it is held. The third is an automatic mode that watches the device's activity and powers it down after a 10 ms quiet period.

The automatic path runs a countdown timer while the auto enable bit is set. Any read of the main status register or any access to the data register reloads the timer. A status value that is not the idle code (80h) also reloads it, and so does a rising interrupt flag. Auto powerdown is entered only when all of the following hold together:

- the timer has reached zero;
- every motor-enable bit is low;
- the status reads 80h with the interrupt flag low;
- the head-unload timer has expired.

An access while auto powered down wakes the device and starts a fresh countdown. The output reports both whether the device is down and which request is responsible. The timer length is derived from the clock frequency parameter.

Top module: `disk_pwr_ctrl`

## Requirements
- R1: After reset, pd_o is 0 and pd_src_o is 0 (source codes: 0 none, 1 auto, 2 data-rate, 3 direct).
- R2: direct_pd_i high at a clock edge makes pd_src_o equal 3 and pd_o 1 after that edge, whatever the other inputs are. Removing it releases the state one edge later.
- R3: With auto_en_i set and all idle conditions held, pd_src_o becomes 1 exactly LOAD+2 edges after the first edge that samples auto_en_i high, where LOAD = CLK_KHZ*IDLE_MS. It is not 1 before that.
- R4: No auto powerdown occurs while any motor_en_i bit is 1, while head_unload_done_i is 0, or while irq_i is 1. Raising any of these while auto powered down releases pd_o within two edges.
- R5: A status read or data access during the countdown reloads the timer, so auto powerdown follows LOAD+3 edges after the edge that sampled the latest access.
- R6: A status read or data access while auto powered down clears pd_o two edges later and restarts a full countdown.
- R7: While auto_en_i is 0, the device is never auto powered down. Clearing auto_en_i releases an auto powerdown within two edges, and setting it again starts a fresh full countdown.
- R8: rate_pd_i overrides auto powerdown and reports source 2 one edge after it is sampled. direct_pd_i in turn overrides rate_pd_i.
- R9: When rate_pd_i is released and the auto conditions still hold, the state returns to auto powerdown (source 1) one edge later, without a new countdown.
- R10: status_i other than 80h, or a rising edge of irq_i, reloads the timer. Auto powerdown then needs a full countdown after the status returns to 80h.
- R11: Motor-enable bits and the head-unload flag block powerdown without reloading the timer. Once they clear after the timer has expired, auto powerdown follows two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_pd_i | input | 1 | Direct powerdown configuration bit |
| auto_en_i | input | 1 | Auto powerdown enable |
| rate_pd_i | input | 1 | Data-rate register powerdown bit |
| motor_en_i | input | N_MOTOR | Motor-enable bits |
| status_i | input | 8 | Main status register value |
| irq_i | input | 1 | Controller interrupt flag |
| head_unload_done_i | input | 1 | Head-unload timer expired |
| status_rd_i | input | 1 | Main status register read strobe |
| data_acc_i | input | 1 | Data register access strobe |
| pd_o | output | 1 | Device powered down |
| pd_src_o | output | 2 | Source of the powerdown: 0 none, 1 auto, 2 data-rate, 3 direct |

## Verification
The hardest case to reach is the difference between a condition that reloads the timer and one that only blocks entry. Both keep the device awake while they are held, so they can only be told apart by when powerdown arrives after they are removed. The stimulus therefore holds a motor bit, a low head-unload flag, a high interrupt and a non-idle status, each for longer than the full countdown. It then releases them and checks whether powerdown follows in two edges or only after a complete new count. A small LOAD parameter makes exact edge counting practical.

// File: rtl/disk_pwr_pkg.sv
package disk_pwr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_AUTO   = 2'd1,
    SRC_RATE   = 2'd2,
    SRC_DIRECT = 2'd3
  } pd_src_e;

  localparam logic [7:0] IDLE_STATUS = 8'h80;
endpackage

// File: rtl/pd_idle_qual.sv
module pd_idle_qual
  import disk_pwr_pkg::*;
#(
  parameter int unsigned N_MOTOR = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MOTOR-1:0] motor_en_i,
  input  logic [7:0]         status_i,
  input  logic               irq_i,
  input  logic               head_unload_done_i,
  input  logic               status_rd_i,
  input  logic               data_acc_i,
  output logic               idle_ok_o,
  output logic               access_o,
  output logic               reload_o
);
  logic irq_q;
  logic status_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_i;
  end

  assign status_idle = (status_i == IDLE_STATUS);
  assign access_o    = status_rd_i | data_acc_i;
  // busy status or a new interrupt restarts the quiet period
  assign reload_o    = access_o | ~status_idle | (irq_i & ~irq_q);
  assign idle_ok_o   = ~(|motor_en_i) & status_idle & ~irq_i & head_unload_done_i;
endmodule

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
  parameter int unsigned LOAD  = 1250000,
  parameter int unsigned CNT_W = $clog2(LOAD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic reload_i,
  output logic zero_o
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

  logic [CNT_W-1:0] cnt_q;

  // held at LOAD while disabled, so enabling starts a full count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= LOAD_V;
    else if (!en_i || reload_i) cnt_q <= LOAD_V;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pd_state_arb.sv
module pd_state_arb
  import disk_pwr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    direct_pd_i,
  input  logic    rate_pd_i,
  input  logic    auto_en_i,
  input  logic    zero_i,
  input  logic    idle_ok_i,
  input  logic    access_i,
  output pd_src_e src_o
);
  logic    auto_q;
  pd_src_e st_d, st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) auto_q <= 1'b0;
    else         auto_q <= auto_en_i & zero_i & idle_ok_i & ~access_i;
  end

  // direct > data-rate > auto; auto_q keeps running under the overrides
  always_comb begin
    if (direct_pd_i)    st_d = SRC_DIRECT;
    else if (rate_pd_i) st_d = SRC_RATE;
    else if (auto_q)    st_d = SRC_AUTO;
    else                st_d = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SRC_NONE;
    else         st_q <= st_d;
  end

  assign src_o = st_q;
endmodule

// File: rtl/disk_pwr_ctrl.sv
module disk_pwr_ctrl
  import disk_pwr_pkg::*;
#(
  parameter int unsigned N_MOTOR = 4,
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned IDLE_MS = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               direct_pd_i,
  input  logic               auto_en_i,
  input  logic               rate_pd_i,
  input  logic [N_MOTOR-1:0] motor_en_i,
  input  logic [7:0]         status_i,
  input  logic               irq_i,
  input  logic               head_unload_done_i,
  input  logic               status_rd_i,
  input  logic               data_acc_i,
  output logic               pd_o,
  output logic [1:0]         pd_src_o
);
  localparam int unsigned LOAD  = CLK_KHZ * IDLE_MS;
  localparam int unsigned CNT_W = $clog2(LOAD + 1);

  logic    idle_ok, access, reload, zero;
  pd_src_e src;

  pd_idle_qual #(.N_MOTOR(N_MOTOR)) u_qual (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .motor_en_i         (motor_en_i),
    .status_i           (status_i),
    .irq_i              (irq_i),
    .head_unload_done_i (head_unload_done_i),
    .status_rd_i        (status_rd_i),
    .data_acc_i         (data_acc_i),
    .idle_ok_o          (idle_ok),
    .access_o           (access),
    .reload_o           (reload)
  );

  pd_idle_timer #(.LOAD(LOAD), .CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (auto_en_i),
    .reload_i (reload),
    .zero_o   (zero)
  );

  pd_state_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .direct_pd_i (direct_pd_i),
    .rate_pd_i   (rate_pd_i),
    .auto_en_i   (auto_en_i),
    .zero_i      (zero),
    .idle_ok_i   (idle_ok),
    .access_i    (access),
    .src_o       (src)
  );

  assign pd_src_o = src;
  assign pd_o     = (src != SRC_NONE);
endmodule

// File: rtl/disk_pwr_ctrl_chk.sv
module disk_pwr_ctrl_chk #(
  parameter int unsigned N_MOTOR = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               direct_pd_i,
  input logic               auto_en_i,
  input logic               rate_pd_i,
  input logic [N_MOTOR-1:0] motor_en_i,
  input logic [7:0]         status_i,
  input logic               head_unload_done_i,
  input logic               status_rd_i,
  input logic               data_acc_i,
  input logic [1:0]         pd_src_o
);
  AST_DIRECT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_pd_i |=> pd_src_o == 2'd3); // R2

  AST_RATE_OVER_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_pd_i && !direct_pd_i) |=> pd_src_o == 2'd2); // R8

  AST_AUTO_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_src_o == 2'd1) |-> ($past(motor_en_i, 2) == '0 && $past(head_unload_done_i, 2)
                           && $past(status_i, 2) == 8'h80)); // R4

  AST_ACCESS_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i || data_acc_i) |=> ##1 (pd_src_o != 2'd1)); // R6

  AST_DISABLED_NO_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> ##1 (pd_src_o != 2'd1)); // R7
endmodule

bind disk_pwr_ctrl disk_pwr_ctrl_chk #(.N_MOTOR(N_MOTOR)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .direct_pd_i        (direct_pd_i),
  .auto_en_i          (auto_en_i),
  .rate_pd_i          (rate_pd_i),
  .motor_en_i         (motor_en_i),
  .status_i           (status_i),
  .head_unload_done_i (head_unload_done_i),
  .status_rd_i        (status_rd_i),
  .data_acc_i         (data_acc_i),
  .pd_src_o           (pd_src_o)
);

// File: tb/disk_pwr_ctrl_bench.sv
module disk_pwr_ctrl_bench;
  localparam int unsigned NM = 4;
  localparam int unsigned CK = 4;
  localparam int unsigned MS = 10;
  localparam int unsigned L  = CK * MS;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          direct_pd_i = 1'b0, auto_en_i = 1'b0, rate_pd_i = 1'b0;
  logic [NM-1:0] motor_en_i = '0;
  logic [7:0]    status_i = 8'h80;
  logic          irq_i = 1'b0, head_unload_done_i = 1'b1;
  logic          status_rd_i = 1'b0, data_acc_i = 1'b0;
  logic          pd_o;
  logic [1:0]    pd_src_o;

  disk_pwr_ctrl #(.N_MOTOR(NM), .CLK_KHZ(CK), .IDLE_MS(MS)) u_disk_pwr_ctrl (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    int unsigned cyc;
    logic        pd;
    logic [1:0]  src;
    string       tag;
  } exp_t;

  exp_t        q[$];
  exp_t        e;
  int unsigned cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (pd_o !== e.pd || pd_src_o !== e.src) begin
        n_fail++;
        $display("FAIL %s: pd=%0b src=%0d expected pd=%0b src=%0d", e.tag, pd_o, pd_src_o, e.pd, e.src);
      end
    end
  end

  task automatic expect_in(int unsigned d, logic pd, logic [1:0] src, string tag);
    exp_t x;
    x.cyc = cyc + d; x.pd = pd; x.src = src; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic step(int unsigned n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    expect_in(1, 1'b0, 2'd0, "R1");
    step(2);
    // disabled: never auto powers down
    expect_in(L + 10, 1'b0, 2'd0, "R7");
    step(L + 10);
    // enable: exact entry edge
    auto_en_i = 1'b1;
    expect_in(L + 1, 1'b0, 2'd0, "R3");
    expect_in(L + 2, 1'b1, 2'd1, "R3");
    step(L + 2);
    // access while down wakes, then full count
    status_rd_i = 1'b1;
    expect_in(1, 1'b1, 2'd1, "R6");
    expect_in(2, 1'b0, 2'd0, "R6");
    expect_in(L + 2, 1'b0, 2'd0, "R6");
    expect_in(L + 3, 1'b1, 2'd1, "R6");
    step(1); status_rd_i = 1'b0;
    step(L + 2);
    // access during countdown reloads
    data_acc_i = 1'b1;
    expect_in(2, 1'b0, 2'd0, "R5");
    step(1); data_acc_i = 1'b0;
    step(19);
    data_acc_i = 1'b1;
    expect_in(L - 17, 1'b0, 2'd0, "R5");
    expect_in(L + 2, 1'b0, 2'd0, "R5");
    expect_in(L + 3, 1'b1, 2'd1, "R5");
    step(1); data_acc_i = 1'b0;
    step(L + 2);
    // busy status pulse reloads
    status_i = 8'h81;
    expect_in(2, 1'b0, 2'd0, "R10");
    expect_in(L + 2, 1'b0, 2'd0, "R10");
    expect_in(L + 3, 1'b1, 2'd1, "R10");
    step(1); status_i = 8'h80;
    step(L + 2);
    // interrupt rise reloads
    irq_i = 1'b1;
    expect_in(2, 1'b0, 2'd0, "R10");
    expect_in(L + 2, 1'b0, 2'd0, "R10");
    expect_in(L + 3, 1'b1, 2'd1, "R10");
    step(1); irq_i = 1'b0;
    step(L + 2);
    // motor blocks without reload
    motor_en_i = 4'b0010;
    expect_in(2, 1'b0, 2'd0, "R4");
    expect_in(L + 10, 1'b0, 2'd0, "R4");
    step(L + 10);
    motor_en_i = '0;
    expect_in(1, 1'b0, 2'd0, "R11");
    expect_in(2, 1'b1, 2'd1, "R11");
    step(2);
    // head-unload not expired blocks without reload
    head_unload_done_i = 1'b0;
    expect_in(2, 1'b0, 2'd0, "R4");
    expect_in(L + 10, 1'b0, 2'd0, "R4");
    step(L + 10);
    head_unload_done_i = 1'b1;
    expect_in(1, 1'b0, 2'd0, "R11");
    expect_in(2, 1'b1, 2'd1, "R11");
    step(2);
    // interrupt held high blocks
    irq_i = 1'b1;
    expect_in(2, 1'b0, 2'd0, "R4");
    expect_in(L + 10, 1'b0, 2'd0, "R4");
    step(L + 10);
    irq_i = 1'b0;
    expect_in(2, 1'b1, 2'd1, "R4");
    step(2);
    // busy status held reloads continuously
    status_i = 8'h10;
    expect_in(L + 10, 1'b0, 2'd0, "R10");
    step(L + 10);
    status_i = 8'h80;
    expect_in(L + 1, 1'b0, 2'd0, "R10");
    expect_in(L + 2, 1'b1, 2'd1, "R10");
    step(L + 2);
    // precedence and resume
    rate_pd_i = 1'b1;
    expect_in(1, 1'b1, 2'd2, "R8");
    step(3);
    direct_pd_i = 1'b1;
    expect_in(1, 1'b1, 2'd3, "R8");
    step(2);
    direct_pd_i = 1'b0;
    expect_in(1, 1'b1, 2'd2, "R8");
    step(2);
    rate_pd_i = 1'b0;
    expect_in(1, 1'b1, 2'd1, "R9");
    step(2);
    // disable cancels, re-enable counts afresh
    auto_en_i = 1'b0;
    expect_in(1, 1'b1, 2'd1, "R7");
    expect_in(2, 1'b0, 2'd0, "R7");
    expect_in(L + 10, 1'b0, 2'd0, "R7");
    step(L + 10);
    auto_en_i = 1'b1;
    expect_in(L + 1, 1'b0, 2'd0, "R7");
    expect_in(L + 2, 1'b1, 2'd1, "R7");
    step(L + 2);
    // direct powerdown with auto disabled
    auto_en_i = 1'b0;
    step(3);
    direct_pd_i = 1'b1;
    expect_in(1, 1'b1, 2'd3, "R2");
    step(2);
    direct_pd_i = 1'b0;
    expect_in(1, 1'b0, 2'd0, "R2");
    step(3);
    while (q.size() > 0) step(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule